// File: doc/BRIEF.md
# Self-Checking Modular Exponentiation Unit

This unit computes `x^y mod N` and checks its own answer against faults. One request runs the exponentiation twice. Each pass uses its own pair of masking multipliers. The base is masked by adding a multiple of the modulus, `x + kx*N`. The exponent is masked by adding a multiple of Euler's totient, `y + ky*phi`. For a base coprime to `N`, both passes land on the same residue. A fault that disturbs one pass makes the two residues disagree, and the unit then raises an error flag and withholds the value.

Operands are loaded with a one-cycle `start` while `ready` is high. The exponent is walked from its most significant bit down with a square-and-multiply loop. A single bit-serial shift-add modular multiplier is shared by both passes. A bit-serial reducer brings the masked base below `N` once at the start of each pass. A test input can corrupt the first pass on purpose so that the detection path can be exercised.

Top module: `mexp_guard`

## Requirements
- R1: While reset is asserted and after it is released with no request, `ready` is 1, and `done`, `err` and `result` are 0.
- R2: For `2 <= modulus`, a base coprime to the modulus, and any multipliers, a fault-free request returns `result = base^expo mod modulus`. Values of `base` at or above the modulus are allowed.
- R3: Pass A masks the operands with (`kx_a`, `ky_a`) and pass B with (`kx_b`, `ky_b`), as `base + kx*modulus` and `expo + ky*phi`. Any multiplier values, zero or the maximum (255 by default), leave the result unchanged.
- R4: When the two pass residues agree, `err` is 0 and `result` carries the common residue.
- R5: With `inj_en` = 1, bit `inj_bit` (bit 0 = least significant) of pass A's final residue is inverted, then reduced once by the modulus if it is not below it. Given `2^inj_bit < modulus`, the request ends with `err` = 1 and `result` = 0.
- R6: `ready` falls the cycle after a start is accepted, stays low while the request runs, and is high again in the cycle where `done` is high.
- R7: `done` is high for exactly one cycle per accepted request.
- R8: `start` while `ready` is low is ignored. No extra `done` appears, and the running request's result is not changed.
- R9: An exponent of 0, or a base of 1, yields `result` = 1.
- R10: `result` and `err` hold their values after `done` until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken when `ready` is 1 |
| ready | output | 1 | Unit idle and able to accept a request |
| base | input | NW | Base x |
| expo | input | NW | Exponent y |
| modulus | input | NW | Modulus N |
| phi | input | NW | Euler totient of N |
| kx_a | input | KW | Base multiplier, pass A |
| ky_a | input | KW | Exponent multiplier, pass A |
| kx_b | input | KW | Base multiplier, pass B |
| ky_b | input | KW | Exponent multiplier, pass B |
| inj_en | input | 1 | Corrupt pass A's final residue (test) |
| inj_bit | input | $clog2(NW) | Bit index to invert |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Pass residues disagreed |
| result | output | NW | Checked residue, 0 when `err` is 1 |

## Verification
The bench targets several corner cases, each paired with the failure it would expose:
- Zero and maximum multipliers: a bad mask adder or a truncated masked exponent gives a residue that is off.
- A zero exponent and a unit base: a loop that starts the accumulator wrongly gives an answer other than 1.
- A base above the modulus: a reducer that skips bits leaves the base unreduced.
- A modulus near 2^32: a missing guard bit in the multiplier's intermediate sum overflows it.
- Injected faults at low and high bit positions: `err` must rise and the value must be held back, or the comparison is dead.
- A start pulse in mid-run with different operands: if it is honoured, a second `done` or a wrong value shows up in the scoreboard.

// File: rtl/mexp_pkg.sv
package mexp_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LOAD,
    ST_RED,
    ST_SQ,
    ST_SQW,
    ST_MUL,
    ST_MULW,
    ST_STEP,
    ST_END
  } mexp_state_e;

  typedef enum logic {
    PASS_A = 1'b0,
    PASS_B = 1'b1
  } mexp_pass_e;

endpackage

// File: rtl/mexp_modmul.sv
module mexp_modmul #(
  parameter int NW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [NW-1:0] op_a,
  input  logic [NW-1:0] op_b,
  input  logic [NW-1:0] op_n,
  output logic          fin,
  output logic [NW-1:0] prod
);
  localparam int CW = $clog2(NW) + 1;

  // One interleaved step: acc <- (2*acc + bit*b) mod n, for acc < n and b < n.
  function automatic logic [NW-1:0] mm_step(input logic [NW-1:0] acc,
                                             input logic          bit_i,
                                             input logic [NW-1:0] bb,
                                             input logic [NW-1:0] nn);
    logic [NW+1:0] t;
    logic [NW+1:0] nx;
    nx = {2'b00, nn};
    t  = {1'b0, acc, 1'b0};
    if (t >= nx) t = t - nx;
    if (bit_i)   t = t + {2'b00, bb};
    if (t >= nx) t = t - nx;
    return t[NW-1:0];
  endfunction

  logic          busy_q;
  logic          fin_q;
  logic [NW-1:0] a_q, b_q, n_q, acc_q;
  logic [CW-1:0] cnt_q;
  logic          step_last;

  assign step_last = busy_q && (cnt_q == CW'(NW - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      a_q    <= '0;
      b_q    <= '0;
      n_q    <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
    end else begin
      fin_q <= 1'b0;
      if (go) begin
        busy_q <= 1'b1;
        a_q    <= op_a;
        b_q    <= op_b;
        n_q    <= op_n;
        acc_q  <= '0;
        cnt_q  <= '0;
      end else if (busy_q) begin
        acc_q <= mm_step(acc_q, a_q[NW-1], b_q, n_q);
        a_q   <= {a_q[NW-2:0], 1'b0};
        cnt_q <= cnt_q + CW'(1);
        if (step_last) begin
          busy_q <= 1'b0;
          fin_q  <= 1'b1;
        end
      end
    end
  end

  assign fin  = fin_q;
  assign prod = acc_q;

  // Product handed back is always fully reduced (R2).
  p_mul_reduced_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (prod < n_q));

  // A finished product is announced exactly one cycle after the last step.
  p_mul_fin_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_last && !go |=> fin);

endmodule

// File: rtl/mexp_reducer.sv
module mexp_reducer #(
  parameter int NW = 32,
  parameter int IW = 41
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [IW-1:0] val,
  input  logic [NW-1:0] op_n,
  output logic          fin,
  output logic [NW-1:0] rem
);
  localparam int CW = $clog2(IW) + 1;

  // r <- (2r + bit) mod n for r < n; one subtraction suffices.
  function automatic logic [NW-1:0] rd_step(input logic [NW-1:0] r,
                                            input logic          bit_i,
                                            input logic [NW-1:0] nn);
    logic [NW:0] t;
    t = {r, bit_i};
    if (t >= {1'b0, nn}) t = t - {1'b0, nn};
    return t[NW-1:0];
  endfunction

  logic          busy_q;
  logic          fin_q;
  logic [IW-1:0] v_q;
  logic [NW-1:0] n_q, r_q;
  logic [CW-1:0] cnt_q;
  logic          step_last;

  assign step_last = busy_q && (cnt_q == CW'(IW - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      v_q    <= '0;
      n_q    <= '0;
      r_q    <= '0;
      cnt_q  <= '0;
    end else begin
      fin_q <= 1'b0;
      if (go) begin
        busy_q <= 1'b1;
        v_q    <= val;
        n_q    <= op_n;
        r_q    <= '0;
        cnt_q  <= '0;
      end else if (busy_q) begin
        r_q   <= rd_step(r_q, v_q[IW-1], n_q);
        v_q   <= {v_q[IW-2:0], 1'b0};
        cnt_q <= cnt_q + CW'(1);
        if (step_last) begin
          busy_q <= 1'b0;
          fin_q  <= 1'b1;
        end
      end
    end
  end

  assign fin = fin_q;
  assign rem = r_q;

  // Reduced base is below the modulus (R2).
  p_red_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (rem < n_q));

  // No new reduction is launched while one is in flight.
  p_red_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !go);

endmodule

// File: rtl/mexp_guard.sv
module mexp_guard #(
  parameter int NW = 32,
  parameter int KW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  output logic                  ready,
  input  logic [NW-1:0]         base,
  input  logic [NW-1:0]         expo,
  input  logic [NW-1:0]         modulus,
  input  logic [NW-1:0]         phi,
  input  logic [KW-1:0]         kx_a,
  input  logic [KW-1:0]         ky_a,
  input  logic [KW-1:0]         kx_b,
  input  logic [KW-1:0]         ky_b,
  input  logic                  inj_en,
  input  logic [$clog2(NW)-1:0] inj_bit,
  output logic                  done,
  output logic                  err,
  output logic [NW-1:0]         result
);
  import mexp_pkg::*;

  localparam int EW  = NW + KW + 1;      // masked operand width incl. carry
  localparam int IXW = $clog2(EW);
  localparam int IBW = $clog2(NW);

  // v + k*m, the masking used for both base and exponent.
  function automatic logic [EW-1:0] mask_add(input logic [NW-1:0] v,
                                             input logic [KW-1:0] k,
                                             input logic [NW-1:0] m);
    return EW'(v) + EW'(k) * EW'(m);
  endfunction

  // Invert one bit, then pull back below the modulus once.
  function automatic logic [NW-1:0] corrupt(input logic [NW-1:0] v,
                                            input logic [IBW-1:0] b,
                                            input logic [NW-1:0] nn);
    logic [NW-1:0] f;
    f = v ^ (NW'(1) << b);
    return (f >= nn) ? f - nn : f;
  endfunction

  mexp_state_e   state_q;
  mexp_pass_e    pass_q;
  logic [NW-1:0] x_q, y_q, n_q, phi_q;
  logic [KW-1:0] kxa_q, kya_q, kxb_q, kyb_q;
  logic          inj_q;
  logic [IBW-1:0] ibit_q;
  logic [EW-1:0] yenc_q;
  logic [NW-1:0] base_q, acc_q, res_a_q;
  logic [IXW-1:0] idx_q;
  logic          done_q, err_q;
  logic [NW-1:0] result_q;

  // Named internal events.
  logic          accept;
  logic          pass_end;
  logic          run_done;
  logic          mismatch;
  logic [KW-1:0] kx_sel, ky_sel;
  logic [NW-1:0] inj_mask;

  assign accept   = start && (state_q == ST_IDLE);
  assign pass_end = (state_q == ST_END);
  assign run_done = pass_end && (pass_q == PASS_B);
  assign mismatch = (res_a_q != acc_q);
  assign kx_sel   = (pass_q == PASS_B) ? kxb_q : kxa_q;
  assign ky_sel   = (pass_q == PASS_B) ? kyb_q : kya_q;
  assign inj_mask = NW'(1) << ibit_q;

  // Shared datapath units.
  logic          red_go, red_fin;
  logic [NW-1:0] red_rem;
  logic          mul_go, mul_fin;
  logic [NW-1:0] mul_b, mul_prod;

  assign red_go = (state_q == ST_LOAD);
  assign mul_go = (state_q == ST_SQ) || (state_q == ST_MUL);
  assign mul_b  = (state_q == ST_MUL) ? base_q : acc_q;

  mexp_reducer #(.NW(NW), .IW(EW)) u_red (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (red_go),
    .val  (mask_add(x_q, kx_sel, n_q)),
    .op_n (n_q),
    .fin  (red_fin),
    .rem  (red_rem)
  );

  mexp_modmul #(.NW(NW)) u_mul (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (mul_go),
    .op_a (acc_q),
    .op_b (mul_b),
    .op_n (n_q),
    .fin  (mul_fin),
    .prod (mul_prod)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pass_q   <= PASS_A;
      x_q      <= '0;
      y_q      <= '0;
      n_q      <= '0;
      phi_q    <= '0;
      kxa_q    <= '0;
      kya_q    <= '0;
      kxb_q    <= '0;
      kyb_q    <= '0;
      inj_q    <= 1'b0;
      ibit_q   <= '0;
      yenc_q   <= '0;
      base_q   <= '0;
      acc_q    <= '0;
      res_a_q  <= '0;
      idx_q    <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      result_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            x_q     <= base;
            y_q     <= expo;
            n_q     <= modulus;
            phi_q   <= phi;
            kxa_q   <= kx_a;
            kya_q   <= ky_a;
            kxb_q   <= kx_b;
            kyb_q   <= ky_b;
            inj_q   <= inj_en;
            ibit_q  <= inj_bit;
            pass_q  <= PASS_A;
            state_q <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          yenc_q  <= mask_add(y_q, ky_sel, phi_q);
          state_q <= ST_RED;
        end
        ST_RED: begin
          if (red_fin) begin
            base_q  <= red_rem;
            acc_q   <= (n_q == NW'(1)) ? '0 : NW'(1);
            idx_q   <= IXW'(EW - 1);
            state_q <= ST_SQ;
          end
        end
        ST_SQ:  state_q <= ST_SQW;
        ST_SQW: begin
          if (mul_fin) begin
            acc_q   <= mul_prod;
            state_q <= yenc_q[idx_q] ? ST_MUL : ST_STEP;
          end
        end
        ST_MUL: state_q <= ST_MULW;
        ST_MULW: begin
          if (mul_fin) begin
            acc_q   <= mul_prod;
            state_q <= ST_STEP;
          end
        end
        ST_STEP: begin
          if (idx_q == '0) begin
            state_q <= ST_END;
          end else begin
            idx_q   <= idx_q - IXW'(1);
            state_q <= ST_SQ;
          end
        end
        ST_END: begin
          if (pass_q == PASS_A) begin
            res_a_q <= inj_q ? corrupt(acc_q, ibit_q, n_q) : acc_q;
            pass_q  <= PASS_B;
            state_q <= ST_LOAD;
          end else begin
            done_q   <= 1'b1;
            err_q    <= mismatch;
            result_q <= mismatch ? '0 : acc_q;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready  = (state_q == ST_IDLE);
  assign done   = done_q;
  assign err    = err_q;
  assign result = result_q;

  // R7: completion is a single-cycle pulse.
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: ready drops after an accepted start, and is back when done rises.
  p_ready_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);
  p_ready_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready);

  // R8: a start during a run leaves the captured operands untouched.
  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !ready) |=> ($stable(n_q) && $stable(y_q) && $stable(x_q)));

  // R5: a valid injected fault is always flagged and the value withheld.
  p_fault_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_done && inj_q && (inj_mask < n_q)) |=> (err && (result == '0)));

  // R4: a flagged error never releases a value.
  p_err_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (result == '0));

  // R10: outputs hold between completions.
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(run_done)) |-> ($stable(result) && $stable(err)));

endmodule

// File: tb/mexp_guard_tb_top.sv
module mexp_guard_tb_top;
  localparam int NW  = 32;
  localparam int KW  = 8;
  localparam int IBW = $clog2(NW);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic           ready;
  logic [NW-1:0]  base = '0, expo = '0, modulus = '0, phi = '0;
  logic [KW-1:0]  kx_a = '0, ky_a = '0, kx_b = '0, ky_b = '0;
  logic           inj_en = 1'b0;
  logic [IBW-1:0] inj_bit = '0;
  logic           done, err;
  logic [NW-1:0]  result;

  always #10 clk = ~clk;   // 50 MHz

  mexp_guard #(.NW(NW), .KW(KW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
    .base(base), .expo(expo), .modulus(modulus), .phi(phi),
    .kx_a(kx_a), .ky_a(ky_a), .kx_b(kx_b), .ky_b(ky_b),
    .inj_en(inj_en), .inj_bit(inj_bit),
    .done(done), .err(err), .result(result)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  // Scoreboard queues.
  longint unsigned q_res[$];
  bit              q_err[$];
  string           q_tag[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint unsigned act, input longint unsigned expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  // Independent square-and-multiply on the plain exponent.
  function automatic longint unsigned ref_pow(input longint unsigned x,
                                              input longint unsigned y,
                                              input longint unsigned n);
    longint unsigned r, b;
    r = 1 % n;
    b = x % n;
    for (int i = 31; i >= 0; i--) begin
      r = (r * r) % n;
      if (y[i]) r = (r * b) % n;
    end
    return r;
  endfunction

  task automatic drive_op(input longint unsigned x, input longint unsigned y,
                          input longint unsigned n, input longint unsigned ph,
                          input int k0, input int k1, input int k2, input int k3,
                          input bit inj, input int ib);
    base = NW'(x); expo = NW'(y); modulus = NW'(n); phi = NW'(ph);
    kx_a = KW'(k0); ky_a = KW'(k1); kx_b = KW'(k2); ky_b = KW'(k3);
    inj_en = inj; inj_bit = IBW'(ib);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_op(input longint unsigned x, input longint unsigned y,
                        input longint unsigned n, input longint unsigned ph,
                        input int k0, input int k1, input int k2, input int k3,
                        input bit inj, input int ib, input string tag);
    while (!ready) @(negedge clk);
    if (inj) begin
      q_res.push_back(0);
      q_err.push_back(1'b1);
    end else begin
      q_res.push_back(ref_pow(x, y, n));
      q_err.push_back(1'b0);
    end
    q_tag.push_back(tag);
    drive_op(x, y, n, ph, k0, k1, k2, k3, inj, ib);
    chk(ready == 1'b0, "R6", "ready after start", ready, 0);
  endtask

  // Monitor: pops expected items as completions appear.
  bit prev_done = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done) chk(0, "R7", "done wider than one cycle", 1, 0);
      if (done) begin
        chk(ready == 1'b1, "R6", "ready at done", ready, 1);
        if (q_res.size() == 0) begin
          chk(0, "R8", "unexpected done", 1, 0);
        end else begin
          automatic longint unsigned er = q_res.pop_front();
          automatic bit ee = q_err.pop_front();
          automatic string t = q_tag.pop_front();
          chk(longint'(result) == er, t, "result", result, er);
          chk(err == ee, t, "err flag", err, ee);
        end
      end
      prev_done = done;
    end
  end

  // Watchdog.
  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "WATCHDOG", "run did not finish", 0, 1);
    wrap_up();
  end

  localparam longint unsigned NS = 3233, PS = 3120;                 // 53*61
  localparam longint unsigned NB = 64'd4292870399, PB = 64'd4292739360; // 65521*65519

  initial begin
    longint unsigned rx, ry;
    int hold_res, hold_err;
    void'($urandom(7));
    // R1: reset state.
    repeat (3) @(negedge clk);
    chk(ready == 1 && done == 0 && err == 0 && result == 0, "R1", "outputs in reset",
        {ready, done, err}, 3'b100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ready == 1 && done == 0 && err == 0 && result == 0, "R1", "outputs after reset",
        {ready, done, err}, 3'b100);

    run_op(65, 17, NS, PS, 3, 5, 7, 2, 0, 0, "R2");
    run_op(123456789, 32'hDEADBEEF, NB, PB, 255, 255, 255, 255, 0, 0, "R3");
    run_op(2, 32'hFFFF_FFFF, NB, PB, 0, 0, 0, 0, 0, 0, "R3");
    run_op(4000, 1234, NS, PS, 9, 1, 200, 77, 0, 0, "R2");
    run_op(987654, 0, NB, PB, 4, 8, 15, 16, 0, 0, "R9");
    run_op(1, 32'h1234_5678, NS, PS, 21, 33, 1, 0, 0, 0, "R9");
    run_op(65, 17, NS, PS, 3, 5, 7, 2, 1, 0, "R5");
    run_op(123456789, 99991, NB, PB, 11, 12, 13, 14, 1, 20, "R5");

    // R10: outputs hold after a completion.
    while (q_res.size() != 0) @(negedge clk);
    hold_res = int'(result);
    hold_err = int'(err);
    repeat (40) @(negedge clk);
    chk(int'(result) == hold_res && int'(err) == hold_err, "R10", "hold after done",
        result, hold_res);

    // R4 with random multipliers on the large modulus.
    for (int i = 0; i < 4; i++) begin
      rx = longint'($urandom) % NB;
      if (rx % 65521 == 0 || rx % 65519 == 0 || rx < 2) rx = 2;
      ry = longint'($urandom);
      run_op(rx, ry, NB, PB, $urandom % 256, $urandom % 256, $urandom % 256,
             $urandom % 256, 0, 0, "R4");
    end

    // R8: start while busy with different operands is ignored.
    run_op(77, 4321, NS, PS, 2, 3, 4, 5, 0, 0, "R8");
    repeat (300) @(negedge clk);
    chk(ready == 1'b0, "R8", "busy before stray start", ready, 0);
    drive_op(5, 6, 35, 24, 1, 1, 1, 1, 1, 0);
    chk(ready == 1'b0, "R8", "ready after stray start", ready, 0);

    while (q_res.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(ready == 1'b1, "R8", "idle after run", ready, 1);
    wrap_up();
  end

endmodule